// File: doc/BRIEF.md
# Hamming Sector Check-and-Repair Engine

This block finds out whether a 512-byte sector that has just been read is intact. To do so it compares two 3-byte Hamming codes. The first is the code that was saved alongside the sector. The second is the code recomputed from the bytes as they were read back. Both codes are first spread into a 32-bit word with a fixed field layout. The two words are then XORed to give a syndrome, and the number of ones in that syndrome decides the outcome. A single flipped data bit produces a syndrome of weight twelve. In that case the block reads the affected byte from the sector RAM, inverts the one faulty bit and writes the byte back.

Other outcomes need no repair. A syndrome of weight one means the saved code itself took the hit, so the data is left alone. A freshly erased sector (saved code all ones, recomputed code all zeros) counts as clean. Every other non-zero syndrome is reported as beyond repair. A one-cycle done pulse presents the verdict, together with the byte and bit that were repaired.

Top module: `hamming_sector_fixer`

## Requirements
- R1: After reset, `done_o`, `ram_rd_o` and `ram_wr_o` are low and `status_o` is 0.
- R2: Each code input carries byte0 in bits 7:0, byte1 in bits 15:8 and byte2 in bits 23:16. It is spread into a 32-bit word as follows: byte0 to bits 7:0, byte1 to bits 23:16, the upper nibble of byte2 to bits 27:24 and the lower nibble of byte2 to bits 11:8, all other bits zero. When the two words are equal, the block reports status 0 (clean) with no RAM access.
- R3: When the syndrome holds exactly twelve ones, the faulty bit is located from the syndrome. The byte index is syndrome bits 27:19 and the bit index is bits 18:16. The block raises `ram_rd_o` for one cycle with that address. The RAM returns the byte on `ram_rdata_i` one cycle later. In that next cycle the block raises `ram_wr_o` with the same address and the byte with the indexed bit inverted. It then reports status 1 (corrected), with the location on `err_byte_o` and `err_bit_o`.
- R4: When the syndrome holds exactly one set bit, the block reports status 2 (code damaged) and does not write the RAM.
- R5: When the spread saved code equals 0x0FFF0FFF and the spread recomputed code is zero, the block reports status 0 (erased sector treated as clean) and does not write the RAM.
- R6: Any other non-zero syndrome gives status 3 (uncorrectable) with no RAM write. This includes a pair that misses the erased pattern by one bit.
- R7: `done_o` is high for exactly one cycle per accepted start. Counting from the clock edge that samples `start_i`, this is the cycle after the second edge when no write is needed, and the cycle after the fourth edge after a repair.
- R8: A `start_i` that arrives while a check is in progress is ignored. It produces no extra done pulse, no extra RAM access and no change to the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check; sampled only when idle |
| stored_code_i | input | 24 | Code saved with the sector |
| calc_code_i | input | 24 | Code recomputed on read |
| ram_addr_o | output | 9 | Sector RAM byte address |
| ram_rd_o | output | 1 | RAM read strobe, data returned next cycle |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | Repaired byte |
| ram_rdata_i | input | 8 | Byte returned by the RAM |
| status_o | output | 2 | Verdict: 0 clean, 1 corrected, 2 code damaged, 3 uncorrectable |
| err_byte_o | output | 9 | Repaired byte index, valid with status 1 |
| err_bit_o | output | 3 | Repaired bit index, valid with status 1 |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives matching code pairs and single-data-bit syndromes at the first byte, the last byte and a middle byte. Because the location is reproduced only if every nibble lands in its proper field, these cases catch a wrong spread. A one-bit syndrome and a two-bit syndrome separate the code-damaged verdict from the uncorrectable one. The exact erased pair, set against a pair that misses it by a single bit, shows that erased-sector recognition matches the whole pattern and not just a heavy syndrome. A second start raised during a repair shows that it leaves the RAM contents, the pulse count and the verdict alone.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    typedef enum logic [1:0] {
        VERDICT_CLEAN    = 2'd0,
        VERDICT_FIXED    = 2'd1,
        VERDICT_CODE_BAD = 2'd2,
        VERDICT_MULTI    = 2'd3
    } verdict_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EVAL  = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } phase_t;

    localparam int CODE_W = 24;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] ERASED_STORED = 32'h0FFF_0FFF;

endpackage

// File: rtl/hsec_repack.sv
module hsec_repack
    import hsec_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [WORD_W-1:0] word_o
);
    // byte0 -> 7:0, byte1 -> 23:16, byte2 upper nibble -> 27:24,
    // byte2 lower nibble -> 11:8, remaining bits zero.
    always_comb begin
        word_o        = '0;
        word_o[7:0]   = code_i[7:0];
        word_o[23:16] = code_i[15:8];
        word_o[27:24] = code_i[23:20];
        word_o[11:8]  = code_i[19:16];
    end
endmodule

// File: rtl/hsec_popcount.sv
module hsec_popcount #(
    parameter int W = 32,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] ones_o
);
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CNT_W'(vec_i[i]);
        end
    end
endmodule

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer
    import hsec_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int DATA_W       = 8,
    parameter int FIX_WEIGHT   = 12,
    localparam int ADDR_W = $clog2(SECTOR_BYTES),
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [23:0]       stored_code_i,
    input  logic [23:0]       calc_code_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic              ram_rd_o,
    output logic              ram_wr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic [1:0]        status_o,
    output logic [ADDR_W-1:0] err_byte_o,
    output logic [BIT_W-1:0]  err_bit_o,
    output logic              done_o
);

    localparam int LOC_LSB  = WORD_W / 2;
    localparam int BYTE_LSB = LOC_LSB + BIT_W;

    typedef struct packed {
        phase_t            phase;
        logic [WORD_W-1:0] syn;
        logic [CNT_W-1:0]  ones;
        logic              erased;
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bit_idx;
        verdict_t          verdict;
        logic              done;
    } state_t;

    state_t r_d, r_q;

    logic [WORD_W-1:0] stored_w, calc_w, syn_now;
    logic [CNT_W-1:0]  ones_now;

    hsec_repack u_pack_stored (.code_i(stored_code_i), .word_o(stored_w));
    hsec_repack u_pack_calc   (.code_i(calc_code_i),   .word_o(calc_w));

    assign syn_now = stored_w ^ calc_w;

    hsec_popcount #(.W(WORD_W)) u_weight (.vec_i(syn_now), .ones_o(ones_now));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.syn    = syn_now;
                    r_d.ones   = ones_now;
                    r_d.erased = (stored_w == ERASED_STORED) && (calc_w == '0);
                    r_d.phase  = PH_EVAL;
                end
            end
            PH_EVAL: begin
                r_d.addr    = r_q.syn[BYTE_LSB +: ADDR_W];
                r_d.bit_idx = r_q.syn[LOC_LSB +: BIT_W];
                if (r_q.syn != '0 && r_q.ones == CNT_W'(FIX_WEIGHT)) begin
                    r_d.phase = PH_READ;
                end else begin
                    r_d.addr    = '0;
                    r_d.bit_idx = '0;
                    r_d.phase   = PH_IDLE;
                    r_d.done    = 1'b1;
                    if (r_q.syn == '0) begin
                        r_d.verdict = VERDICT_CLEAN;
                    end else if (r_q.ones == CNT_W'(1)) begin
                        r_d.verdict = VERDICT_CODE_BAD;
                    end else if (r_q.erased) begin
                        r_d.verdict = VERDICT_CLEAN;
                    end else begin
                        r_d.verdict = VERDICT_MULTI;
                    end
                end
            end
            PH_READ: begin
                r_d.phase = PH_WRITE;
            end
            PH_WRITE: begin
                r_d.phase   = PH_IDLE;
                r_d.verdict = VERDICT_FIXED;
                r_d.done    = 1'b1;
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{phase: PH_IDLE, verdict: VERDICT_CLEAN, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ram_addr_o  = r_q.addr;
    assign ram_rd_o    = (r_q.phase == PH_READ);
    assign ram_wr_o    = (r_q.phase == PH_WRITE);
    assign ram_wdata_o = ram_rdata_i ^ (DATA_W'(1) << r_q.bit_idx);
    assign status_o    = r_q.verdict;
    assign err_byte_o  = r_q.addr;
    assign err_bit_o   = r_q.bit_idx;
    assign done_o      = r_q.done;

endmodule

// File: rtl/hsec_checker.sv
module hsec_checker #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] ram_addr_o,
    input logic              ram_rd_o,
    input logic              ram_wr_o,
    input logic [DATA_W-1:0] ram_wdata_o,
    input logic [DATA_W-1:0] ram_rdata_i,
    input logic [1:0]        status_o,
    input logic              done_o
);
    // R7: completion pulse lasts a single cycle
    assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R3: read and write strobes never coincide
    assert_rw_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ram_rd_o && ram_wr_o));

    // R3: a write is preceded by a read of the same address
    assert_write_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ram_wr_o |-> ($past(ram_rd_o) && $stable(ram_addr_o)));

    // R3: the written byte differs from the returned byte in exactly one bit
    assert_single_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ram_wr_o |-> ($countones(ram_wdata_o ^ ram_rdata_i) == 1));

    // R3: a corrected verdict is reported only right after the write
    assert_fixed_after_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_o == 2'd1) |-> $past(ram_wr_o));

    // R4 / R6: other verdicts never follow a write
    assert_no_write_otherwise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_o != 2'd1) |-> !$past(ram_wr_o));
endmodule

bind hamming_sector_fixer hsec_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hsec_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ram_addr_o  (ram_addr_o),
    .ram_rd_o    (ram_rd_o),
    .ram_wr_o    (ram_wr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_rdata_i (ram_rdata_i),
    .status_o    (status_o),
    .done_o      (done_o)
);

// File: tb/sim_hamming_sector_fixer.sv
module sim_hamming_sector_fixer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic [8:0]  ram_addr;
    logic        ram_rd, ram_wr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [1:0]  status;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;
    logic        done;

    int n_checks = 0;
    int n_fail = 0;
    int n_writes = 0;

    logic [7:0] mem [512];
    logic [7:0] mem_exp [512];

    always #5 clk = ~clk;

    hamming_sector_fixer u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .stored_code_i(stored_code), .calc_code_i(calc_code),
        .ram_addr_o(ram_addr), .ram_rd_o(ram_rd), .ram_wr_o(ram_wr),
        .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
        .status_o(status), .err_byte_o(err_byte), .err_bit_o(err_bit),
        .done_o(done)
    );

    always @(posedge clk) begin
        if (ram_rd) ram_rdata <= mem[ram_addr];
        if (ram_wr) begin
            mem[ram_addr] <= ram_wdata;
            n_writes <= n_writes + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] fold(input logic [31:0] w);
        return {w[27:24], w[11:8], w[23:16], w[7:0]};
    endfunction

    function automatic logic [31:0] single_bit_syn(input int byte_i, input int bit_i);
        logic [11:0] p;
        p = 12'(byte_i * 8 + bit_i);
        return {4'h0, p, 4'h0, ~p};
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 512; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            mem_exp[i] = 8'(i * 7 + 3);
        end
    endtask

    task automatic mem_compare(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 512; i++) if (mem[i] !== mem_exp[i]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    // launches one check; lat = negedge index where done first seen
    task automatic run(input logic [23:0] s, input logic [23:0] c,
                       input bit busy_poke,
                       output int lat, output int ndone, output int st,
                       output int eb, output int ebit);
        lat = 0; ndone = 0; st = -1; eb = -1; ebit = -1;
        @(negedge clk);
        stored_code = s; calc_code = c; start = 1'b1;
        @(negedge clk);
        if (busy_poke) begin
            stored_code = 24'hFFFFFF; calc_code = 24'h000000;
        end else begin
            start = 1'b0;
        end
        for (int i = 1; i <= 8; i++) begin
            if (i == 3) start = 1'b0;
            if (done) begin
                if (lat == 0) begin
                    lat = i; st = int'(status); eb = int'(err_byte); ebit = int'(err_bit);
                end
                ndone++;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(ram_rd == 1'b0 && ram_wr == 1'b0, "R1 ram strobes", int'({ram_rd, ram_wr}), 0);
        check(status == 2'd0, "R1 status", int'(status), 0);
    endtask

    task automatic t_no_fix(input string req, input logic [23:0] s, input logic [23:0] c,
                            input int exp_st);
        int lat, nd, st, eb, eb2, w0;
        w0 = n_writes;
        run(s, c, 1'b0, lat, nd, st, eb, eb2);
        check(st == exp_st, {req, " status"}, st, exp_st);
        check(lat == 2, {req, " R7 latency"}, lat, 2);
        check(nd == 1, {req, " R7 pulse count"}, nd, 1);
        check(n_writes == w0, {req, " no write"}, n_writes - w0, 0);
        mem_compare({req, " memory intact"});
    endtask

    task automatic t_fix(input int byte_i, input int bit_i, input logic [31:0] base,
                         input bit poke);
        int lat, nd, st, eb, ebit, w0;
        logic [31:0] syn;
        syn = single_bit_syn(byte_i, bit_i);
        w0 = n_writes;
        mem_exp[byte_i] = mem_exp[byte_i] ^ 8'(1 << bit_i);
        run(fold(base), fold(base ^ syn), poke, lat, nd, st, eb, ebit);
        check(st == 1, "R3 status corrected", st, 1);
        check(eb == byte_i, "R3 err byte", eb, byte_i);
        check(ebit == bit_i, "R3 err bit", ebit, bit_i);
        check(lat == 4, "R7 latency after repair", lat, 4);
        check(nd == 1, poke ? "R8 single pulse while busy" : "R7 pulse count", nd, 1);
        check(n_writes == w0 + 1, poke ? "R8 single write" : "R3 one write", n_writes - w0, 1);
        mem_compare(poke ? "R8 memory" : "R3 memory");
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        fill_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        t_no_fix("R2 equal codes", 24'h5A3C96, 24'h5A3C96, 0);
        t_no_fix("R2 zero codes", 24'h000000, 24'h000000, 0);

        t_fix(0, 0, 32'h0A5B_0C3D, 1'b0);
        t_fix(511, 7, 32'h0000_0000, 1'b0);
        t_fix(300, 3, 32'h0C81_07E4, 1'b0);

        t_no_fix("R4 code damaged", fold(32'h0312_0456), fold(32'h0312_0456 ^ 32'h0020_0000), 2);
        t_no_fix("R4 code damaged low", 24'h000000, 24'h000080, 2);
        t_no_fix("R5 erased", 24'hFFFFFF, 24'h000000, 0);
        t_no_fix("R6 near erased", 24'hFFFFFF, 24'h000001, 3);
        t_no_fix("R6 two bits", fold(32'h0001_0001), 24'h000000, 3);

        t_fix(100, 6, 32'h0123_0456, 1'b1);
        begin
            int extra;
            extra = 0;
            for (int i = 0; i < 5; i++) begin
                if (done) extra++;
                @(negedge clk);
            end
            check(extra == 0, "R8 no late pulse", extra, 0);
            check(status == 2'd1, "R8 verdict kept", int'(status), 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule